// File: doc/BRIEF.md
# Chained Debug Event Counter

This block counts debug events of a processor with two down-counters. Each cycle it receives one-cycle event strobes: two external debug events, instruction completion, four instruction-address compare hits, read and write hits from two data-address comparators, interrupt taken and interrupt return. Each counter has its own enable mask over these events. Software loads the counts through dedicated load strobes. When a counter steps from one to zero, the block raises a debug-exception request for that counter if the request is enabled.

Counter 1 can run in a gated mode. In that mode it ignores its events until a trigger arms it. The trigger sources are a selectable subset of events, and one of them is counter 2 reaching zero. This lets counter 2 count a prefix of activity before counter 1 starts.

A marker input flags a load-multiple or store-multiple instruction that is in progress. Comparator hits seen while the marker is high give at most one count, and that count is taken when the marker falls. An abort flag cancels the pending count when the instruction is interrupted.

Top module: `dbg_evt_counter`

## Requirements
- R1: The 32-bit control word resets to zero. A write with `ctl_we` is visible on `ctl_rdata` from the next cycle, and every bit reads back as written.
- R2: Event indices are: 0 ext event 1, 1 ext event 2, 2 instruction complete, 3..6 address compares 1..4, 7 data compare 1 read, 8 data compare 1 write, 9 data compare 2 read, 10 data compare 2 write, 11 interrupt taken, 12 interrupt return. The counter-1 enable for event i sits at control bit 31−i (i = 0..12). The counter-2 enable for event i sits at bit 18−i (i = 0..10). Trigger index k sits at bit 7−k, where k is 0 ext 1, 1 ext 2, 2 address compare 1, 3 address compare 3, 4 data compare 1 read, 5 data compare 1 write, 6 counter 2 reaching zero. Bit 0 selects gated mode for counter 1.
- R3: A nonzero counter 1 that is not held by gating decrements by exactly one, at the clock edge that ends a cycle in which at least one of its enabled events is present. This holds however many enabled events coincide. Events that are not enabled have no effect.
- R4: Counter 2 behaves the same way over its 11 events. Interrupt taken and interrupt return never change counter 2.
- R5: A load strobe sets the counter to `ld_value` on the next edge, and the load takes priority over counting. A counter at zero stays at zero until it is reloaded.
- R6: When a counter steps from 1 to 0 and its exception enable is high, its request output is high for exactly the one cycle in which the count first reads zero. With the enable low, the count still steps but no request appears.
- R7: In gated mode, counter 1 does not count until an enabled trigger is seen. The counter is armed from the cycle after the trigger, so events in the trigger cycle itself are not counted. It stays armed until it reaches zero or the control word is written.
- R8: Counter 2 stepping to zero arms counter 1 when trigger 6 is enabled, even when the counter-2 exception enable is low.
- R9: While `multi_busy` is high, comparator hits (indices 3..10) do not count. If any enabled hit occurred during the instruction, the counter decrements once at the edge that ends the first cycle in which `multi_busy` is low.
- R10: If `multi_abort` is high during the instruction or in that first cycle after it, the pending count is dropped.
- R11: Non-comparator events (indices 0..2, 11, 12) count normally while `multi_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_evt | input | 2 | External debug event strobes 1 (bit 0) and 2 (bit 1) |
| instr_done | input | 1 | Instruction complete strobe |
| iac_hit | input | 4 | Instruction-address compare hits 1..4 (bit 0 = compare 1) |
| dac_rd_hit | input | 2 | Data-compare read hits, comparators 1 and 2 |
| dac_wr_hit | input | 2 | Data-compare write hits, comparators 1 and 2 |
| irq_taken | input | 1 | Interrupt taken strobe |
| irq_return | input | 1 | Interrupt return strobe |
| multi_busy | input | 1 | High while a load/store-multiple instruction is in progress |
| multi_abort | input | 1 | Load/store-multiple was interrupted |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word read data |
| cnt1_ld | input | 1 | Load counter 1 |
| cnt2_ld | input | 1 | Load counter 2 |
| ld_value | input | CW | Count value to load |
| exc1_en | input | 1 | Exception enable, counter 1 |
| exc2_en | input | 1 | Exception enable, counter 2 |
| cnt1 | output | CW | Counter 1 value |
| cnt2 | output | CW | Counter 2 value |
| dbg_req1 | output | 1 | Debug-exception request, counter 1 |
| dbg_req2 | output | 1 | Debug-exception request, counter 2 |

## Verification
An event, load or control write presented in one cycle takes effect at the next edge. A request appears in the same cycle as the zero count it reports. A trigger arms counter 1 one edge after it is seen, so the first event that can be counted is the one in the following cycle. A deferred multi-access count lands one edge after the marker's first low cycle. The bench drives every input just after a falling edge and reads the outputs at the next falling edge, so each check sees exactly one rising edge's worth of change.

// File: rtl/dbgcnt_pkg.sv
package dbgcnt_pkg;
   localparam int CTL_W    = 32;
   localparam int C1_NEV   = 13;
   localparam int C2_NEV   = 11;
   localparam int TRG_N    = 7;
   localparam int C1_TOP   = CTL_W - 1;
   localparam int C2_TOP   = C1_TOP - C1_NEV;
   localparam int TRG_TOP  = C2_TOP - C2_NEV;
   localparam int GATE_BIT = TRG_TOP - TRG_N;
   // comparator class: indices 3..10
   localparam logic [C1_NEV-1:0] C1_CMP_MASK = 13'h07F8;
   localparam logic [C2_NEV-1:0] C2_CMP_MASK = 11'h7F8;
endpackage

// File: rtl/dbgcnt_ctl.sv
module dbgcnt_ctl
   import dbgcnt_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [CTL_W-1:0]    wdata,
   output logic [CTL_W-1:0]    rdata,
   output logic [C1_NEV-1:0]   en1,
   output logic [C2_NEV-1:0]   en2,
   output logic [TRG_N-1:0]    trg,
   output logic                gated
);
   logic [CTL_W-1:0] ctl_q;

   if (GATE_BIT != 0) begin : g_bad_layout
      $error("control layout does not fill the word");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  ctl_q <= '0;
      else if (we) ctl_q <= wdata;
   end

   assign rdata = ctl_q;
   assign gated = ctl_q[GATE_BIT];

   for (genvar i = 0; i < C1_NEV; i++) begin : g_en1
      assign en1[i] = ctl_q[C1_TOP-i];
   end
   for (genvar i = 0; i < C2_NEV; i++) begin : g_en2
      assign en2[i] = ctl_q[C2_TOP-i];
   end
   for (genvar k = 0; k < TRG_N; k++) begin : g_trg
      assign trg[k] = ctl_q[TRG_TOP-k];
   end

   AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> rdata == $past(wdata)); // R1
endmodule

// File: rtl/dbgcnt_filt.sv
module dbgcnt_filt #(
   parameter int             NEV      = 13,
   parameter logic [NEV-1:0] CMP_MASK = '0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NEV-1:0] hits,
   input  logic           multi,
   input  logic           multi_end,
   input  logic           abort,
   output logic           step
);
   logic pend_q;
   logic cmp_any, plain_any;

   if (NEV < 1) begin : g_bad_nev
      $error("NEV must be positive");
   end

   assign cmp_any   = |(hits & CMP_MASK);
   assign plain_any = |(hits & ~CMP_MASK);

   always_ff @(posedge clk) begin
      if (!rst_n)                    pend_q <= 1'b0;
      else if (abort || multi_end)   pend_q <= 1'b0;
      else if (multi && cmp_any)     pend_q <= 1'b1;
   end

   assign step = plain_any | (cmp_any & ~multi) | (pend_q & multi_end & ~abort);

   AST_MULTI_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
      (multi && !plain_any) |-> !step); // R9
   AST_ABORT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && multi_end && hits == '0) |-> !step); // R10
endmodule

// File: rtl/dbgcnt_ctr.sv
module dbgcnt_ctr #(
   parameter int CW      = 16,
   parameter bit HAS_ARM = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [CW-1:0] ld_val,
   input  logic          step,
   input  logic          gate_en,
   input  logic          arm_set,
   input  logic          arm_clr,
   input  logic          exc_en,
   output logic [CW-1:0] cnt,
   output logic          zero_hit,
   output logic          req
);
   localparam logic [CW-1:0] ONE = CW'(1);

   logic [CW-1:0] cnt_q;
   logic          req_q;
   logic          may_run;
   logic          dec;

   if (CW < 2) begin : g_bad_cw
      $error("CW must be at least 2");
   end

   if (HAS_ARM) begin : g_arm
      logic arm_q;
      always_ff @(posedge clk) begin
         if (!rst_n)               arm_q <= 1'b0;
         else if (arm_clr)         arm_q <= 1'b0;
         else if (zero_hit)        arm_q <= 1'b0;
         else if (arm_set)         arm_q <= 1'b1;
      end
      assign may_run = !gate_en || arm_q;

      AST_NO_COUNT_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
         (gate_en && !arm_q && !ld) |=> cnt_q == $past(cnt_q)); // R7
   end else begin : g_free
      assign may_run = 1'b1;
   end

   assign dec      = step && may_run && !ld && (cnt_q != '0);
   assign zero_hit = dec && (cnt_q == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         req_q <= 1'b0;
      end else begin
         req_q <= zero_hit && exc_en;
         if (ld)       cnt_q <= ld_val;
         else if (dec) cnt_q <= cnt_q - ONE;
      end
   end

   assign cnt = cnt_q;
   assign req = req_q;

   AST_ZERO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !ld) |=> cnt_q == '0); // R5
   AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && cnt_q != '0) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - ONE)); // R3
   AST_REQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> cnt_q == '0); // R6
endmodule

// File: rtl/dbg_evt_counter.sv
module dbg_evt_counter
   import dbgcnt_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       ext_evt,
   input  logic             instr_done,
   input  logic [3:0]       iac_hit,
   input  logic [1:0]       dac_rd_hit,
   input  logic [1:0]       dac_wr_hit,
   input  logic             irq_taken,
   input  logic             irq_return,
   input  logic             multi_busy,
   input  logic             multi_abort,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic [CTL_W-1:0] ctl_rdata,
   input  logic             cnt1_ld,
   input  logic             cnt2_ld,
   input  logic [CW-1:0]    ld_value,
   input  logic             exc1_en,
   input  logic             exc2_en,
   output logic [CW-1:0]    cnt1,
   output logic [CW-1:0]    cnt2,
   output logic             dbg_req1,
   output logic             dbg_req2
);
   logic [C1_NEV-1:0] ev, en1, hits1;
   logic [C2_NEV-1:0] en2, hits2;
   logic [TRG_N-1:0]  trg, trg_src;
   logic              gated, multi_q, multi_end;
   logic              step1, step2, c1_zero, c2_zero;

   assign ev = {irq_return, irq_taken,
                dac_wr_hit[1], dac_rd_hit[1], dac_wr_hit[0], dac_rd_hit[0],
                iac_hit, instr_done, ext_evt};

   always_ff @(posedge clk) begin
      if (!rst_n) multi_q <= 1'b0;
      else        multi_q <= multi_busy;
   end
   assign multi_end = multi_q & ~multi_busy;

   dbgcnt_ctl u_ctl (
      .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata), .rdata(ctl_rdata),
      .en1(en1), .en2(en2), .trg(trg), .gated(gated)
   );

   assign hits1 = ev & en1;
   assign hits2 = ev[C2_NEV-1:0] & en2;

   dbgcnt_filt #(.NEV(C1_NEV), .CMP_MASK(C1_CMP_MASK)) u_filt1 (
      .clk(clk), .rst_n(rst_n), .hits(hits1), .multi(multi_busy),
      .multi_end(multi_end), .abort(multi_abort), .step(step1)
   );
   dbgcnt_filt #(.NEV(C2_NEV), .CMP_MASK(C2_CMP_MASK)) u_filt2 (
      .clk(clk), .rst_n(rst_n), .hits(hits2), .multi(multi_busy),
      .multi_end(multi_end), .abort(multi_abort), .step(step2)
   );

   dbgcnt_ctr #(.CW(CW), .HAS_ARM(1'b0)) u_ctr2 (
      .clk(clk), .rst_n(rst_n), .ld(cnt2_ld), .ld_val(ld_value), .step(step2),
      .gate_en(1'b0), .arm_set(1'b0), .arm_clr(1'b0), .exc_en(exc2_en),
      .cnt(cnt2), .zero_hit(c2_zero), .req(dbg_req2)
   );

   // trigger order: ext1, ext2, iac1, iac3, dac1 rd, dac1 wr, counter 2 zero
   assign trg_src = {c2_zero, dac_wr_hit[0], dac_rd_hit[0], iac_hit[2], iac_hit[0],
                     ext_evt[1], ext_evt[0]};

   dbgcnt_ctr #(.CW(CW), .HAS_ARM(1'b1)) u_ctr1 (
      .clk(clk), .rst_n(rst_n), .ld(cnt1_ld), .ld_val(ld_value), .step(step1),
      .gate_en(gated), .arm_set(|(trg_src & trg)), .arm_clr(ctl_we), .exc_en(exc1_en),
      .cnt(cnt1), .zero_hit(c1_zero), .req(dbg_req1)
   );

   AST_REQ1_FOLLOWS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_req1 |-> $past(c1_zero)); // R6
   AST_IRQ_NOT_IN_C2: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_taken || irq_return) && hits2 == '0 && !multi_end && !cnt2_ld) |=> $stable(cnt2)); // R4
endmodule

// File: tb/dbg_evt_counter_tb.sv
module dbg_evt_counter_tb;
   localparam int CW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [12:0] evd = '0;
   logic multi_busy = 1'b0, multi_abort = 1'b0;
   logic ctl_we = 1'b0;
   logic [31:0] ctl_wdata = '0;
   logic [31:0] ctl_rdata;
   logic cnt1_ld = 1'b0, cnt2_ld = 1'b0;
   logic [CW-1:0] ld_value = '0;
   logic exc1_en = 1'b0, exc2_en = 1'b0;
   logic [CW-1:0] cnt1, cnt2;
   logic dbg_req1, dbg_req2;
   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   dbg_evt_counter #(.CW(CW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .ext_evt(evd[1:0]), .instr_done(evd[2]), .iac_hit(evd[6:3]),
      .dac_rd_hit({evd[9], evd[7]}), .dac_wr_hit({evd[10], evd[8]}),
      .irq_taken(evd[11]), .irq_return(evd[12]),
      .multi_busy(multi_busy), .multi_abort(multi_abort),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .cnt1_ld(cnt1_ld), .cnt2_ld(cnt2_ld), .ld_value(ld_value),
      .exc1_en(exc1_en), .exc2_en(exc2_en),
      .cnt1(cnt1), .cnt2(cnt2), .dbg_req1(dbg_req1), .dbg_req2(dbg_req2)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // layout per R2
   function automatic logic [31:0] mkctl(input logic [12:0] c1, input logic [10:0] c2,
                                         input logic [6:0] tg, input logic gate);
      logic [31:0] w = '0;
      for (int i = 0; i < 13; i++) w[31-i] = c1[i];
      for (int i = 0; i < 11; i++) w[18-i] = c2[i];
      for (int k = 0; k < 7; k++)  w[7-k]  = tg[k];
      w[0] = gate;
      return w;
   endfunction

   task automatic cyc(input logic [12:0] e, input logic busy, input logic ab);
      evd = e; multi_busy = busy; multi_abort = ab;
      @(negedge clk);
      evd = '0; multi_busy = 1'b0; multi_abort = 1'b0;
   endtask

   task automatic pulse(input logic [12:0] e);
      cyc(e, 1'b0, 1'b0);
   endtask

   task automatic wr_ctl(input logic [31:0] w);
      ctl_we = 1'b1; ctl_wdata = w;
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   task automatic load(input logic [CW-1:0] v1, input logic l1, input logic [CW-1:0] v2, input logic l2);
      if (l1) begin cnt1_ld = 1'b1; ld_value = v1; @(negedge clk); cnt1_ld = 1'b0; end
      if (l2) begin cnt2_ld = 1'b1; ld_value = v2; @(negedge clk); cnt2_ld = 1'b0; end
   endtask

   task automatic t_reset;
      chk("R1 ctl reset", ctl_rdata, 32'h0);
      chk("R5 cnt1 reset", 32'(cnt1), 0);
      chk("R5 cnt2 reset", 32'(cnt2), 0);
      chk("R6 req1 reset", 32'(dbg_req1), 0);
      chk("R6 req2 reset", 32'(dbg_req2), 0);
   endtask

   task automatic t_ctl_rw;
      wr_ctl(32'hA5C3_1E69);
      chk("R1 readback", ctl_rdata, 32'hA5C3_1E69);
      wr_ctl(32'h5A3C_E196);
      chk("R1 readback 2", ctl_rdata, 32'h5A3C_E196);
   endtask

   task automatic t_c1_basic;
      wr_ctl(mkctl(13'h0801, 11'h0, 7'h0, 1'b0)); // ext1 and irq taken
      chk("R2 c1 bits", ctl_rdata, 32'h8010_0000);
      load(16'd5, 1'b1, 16'd0, 1'b0);
      pulse(13'h0001);
      chk("R3 c1 ext1", 32'(cnt1), 4);
      pulse(13'h0801);
      chk("R3 c1 coincident", 32'(cnt1), 3);
      pulse(13'h1002);
      chk("R3 c1 disabled events", 32'(cnt1), 3);
   endtask

   task automatic t_c2_basic;
      wr_ctl(mkctl(13'h0800, 11'h400, 7'h0, 1'b0)); // c1 irq, c2 dac2 write
      chk("R2 c2 bit", ctl_rdata, 32'h0010_0100);
      load(16'd7, 1'b1, 16'd2, 1'b1);
      pulse(13'h0400);
      chk("R4 c2 dac2w", 32'(cnt2), 1);
      chk("R4 c1 unaffected", 32'(cnt1), 7);
      pulse(13'h1800);
      chk("R4 c2 ignores irq", 32'(cnt2), 1);
   endtask

   task automatic t_zero_req;
      wr_ctl(mkctl(13'h0001, 11'h0, 7'h0, 1'b0));
      exc1_en = 1'b1;
      load(16'd1, 1'b1, 16'd0, 1'b0);
      pulse(13'h0001);
      chk("R6 cnt1 zero", 32'(cnt1), 0);
      chk("R6 req1 pulse", 32'(dbg_req1), 1);
      pulse(13'h0001);
      chk("R6 req1 one cycle", 32'(dbg_req1), 0);
      chk("R5 hold zero", 32'(cnt1), 0);
      exc1_en = 1'b0;
      load(16'd1, 1'b1, 16'd0, 1'b0);
      pulse(13'h0001);
      chk("R6 counts w/o enable", 32'(cnt1), 0);
      chk("R6 no req w/o enable", 32'(dbg_req1), 0);
   endtask

   task automatic t_gated;
      wr_ctl(mkctl(13'h0004, 11'h0, 7'h08, 1'b1)); // instr_done, trigger iac3
      load(16'd3, 1'b1, 16'd0, 1'b0);
      pulse(13'h0004);
      chk("R7 unarmed", 32'(cnt1), 3);
      pulse(13'h0024);
      chk("R7 trigger cycle", 32'(cnt1), 3);
      pulse(13'h0004);
      chk("R7 armed", 32'(cnt1), 2);
      pulse(13'h0004);
      pulse(13'h0004);
      chk("R7 to zero", 32'(cnt1), 0);
      load(16'd2, 1'b1, 16'd0, 1'b0);
      pulse(13'h0004);
      chk("R7 disarmed at zero", 32'(cnt1), 2);
      pulse(13'h0020);
      wr_ctl(mkctl(13'h0004, 11'h0, 7'h08, 1'b1));
      pulse(13'h0004);
      chk("R7 disarmed by write", 32'(cnt1), 2);
   endtask

   task automatic t_chain;
      exc2_en = 1'b0;
      wr_ctl(mkctl(13'h0002, 11'h001, 7'h40, 1'b1));
      chk("R2 chain layout", ctl_rdata, 32'h4004_0003);
      load(16'd4, 1'b1, 16'd1, 1'b1);
      pulse(13'h0002);
      chk("R8 before chain", 32'(cnt1), 4);
      pulse(13'h0001);
      chk("R8 cnt2 zero", 32'(cnt2), 0);
      chk("R6 no req2", 32'(dbg_req2), 0);
      pulse(13'h0002);
      chk("R8 armed by cnt2", 32'(cnt1), 3);
   endtask

   task automatic t_multi;
      wr_ctl(mkctl(13'h008C, 11'h0, 7'h0, 1'b0)); // instr_done, iac1, dac1 rd
      load(16'd10, 1'b1, 16'd0, 1'b0);
      cyc(13'h0008, 1'b1, 1'b0);
      chk("R9 held during multi", 32'(cnt1), 10);
      cyc(13'h000C, 1'b1, 1'b0);
      chk("R11 plain event counts", 32'(cnt1), 9);
      cyc(13'h0080, 1'b1, 1'b0);
      chk("R9 still held", 32'(cnt1), 9);
      cyc(13'h0000, 1'b0, 1'b0);
      chk("R9 one count at end", 32'(cnt1), 8);
      cyc(13'h0000, 1'b0, 1'b0);
      chk("R9 no extra count", 32'(cnt1), 8);
   endtask

   task automatic t_abort;
      load(16'd10, 1'b1, 16'd0, 1'b0);
      cyc(13'h0008, 1'b1, 1'b0);
      cyc(13'h0008, 1'b1, 1'b0);
      cyc(13'h0000, 1'b1, 1'b1);
      cyc(13'h0000, 1'b0, 1'b0);
      chk("R10 abort inside", 32'(cnt1), 10);
      cyc(13'h0080, 1'b1, 1'b0);
      cyc(13'h0000, 1'b0, 1'b1);
      cyc(13'h0000, 1'b0, 1'b0);
      chk("R10 abort at end", 32'(cnt1), 10);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctl_rw();
      t_c1_basic();
      t_c2_basic();
      t_zero_req();
      t_gated();
      t_chain();
      t_multi();
      t_abort();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule